// File: doc/BRIEF.md
# Core Interrupt Controller with Force/Clear

This block gathers eight interrupt sources for a small processor core and hands the sequencer one request at a time, together with the address of the service slot to fetch from. Each source owns a four-word slot in a vector table based at zero, so the vector is the source index times four. Three external request lines are active low. Each of them can be set to latch on a falling edge or to follow the line level. A shared peripheral line is always level sensitive, and it lands on slot address 4. Two pulse-type request inputs are latched. Two software sources have no hardware line at all.

Software drives the block through three write-only registers, picked by a select code. The 16-bit force/clear register clears pending bits through its low byte and forces pending bits through its high byte. The configuration register holds three edge-select bits and a nesting enable. The mask register gates which pending sources may be taken. The sequencer answers a request with an acknowledge pulse and ends a service routine with a return pulse. When nesting is off, nothing new is taken until the return arrives. When nesting is on, a small stack of in-service levels lets a strictly more urgent source preempt.

Source map (index = priority, lower wins): 0 external line 0, 1 peripheral, 2 external line 1, 3 software A, 4 software B, 5 external line 2, 6 pulse request 0, 7 pulse request 1.

Top module: `core_irq_ctrl`

## Requirements
- R1: After reset no source is pending, irq_o is 0, the mask is all zero (every source blocked), all external lines are level sensitive and nesting is off.
- R2: A write with wr_sel_i=0 clears the latched pending bit i for every 1 in wr_data_i[i] (i=0..7) and forces pending bit i for every 1 in wr_data_i[8+i]; when both bits for one source are 1, the source ends up pending. The change is visible on pend_o in the cycle after the write edge.
- R3: Sources 3 and 4 become pending only through force bits 11 and 12; no input pin sets them.
- R4: With configuration bit k (k=0..2, wr_sel_i=1) set to 1, a falling edge on ext_n_i[k] latches its source (0, 2, 5 for k=0,1,2) pending three clock edges after the line goes low, and it stays pending after the line returns high.
- R5: A level-sensitive source (external line with its configuration bit 0, or the peripheral line per_req_i) shows pending while its line is active; a clear write or an acknowledge does not drop it, and it drops once the line is released (two edges after release for external lines, at once for per_req_i).
- R6: Among pending sources whose mask bit (wr_sel_i=2, wr_data_i[7:0]) is 1, the lowest index is selected on src_o; when nothing is selectable, src_o reads 0 and irq_o is 0.
- R7: vec_o equals src_o times four; the peripheral source yields 4.
- R8: An acknowledge while irq_o is 1 clears the latched pending bit of the selected source and enters it into service.
- R9: With nesting off (configuration bit 4 = 0), irq_o stays 0 while any source is in service, until a return pulse.
- R10: With nesting on, irq_o rises only for a source of strictly lower index than the newest in-service source and only while fewer than STK_DEPTH levels are in service; a return restores the previous level.
- R11: A high level on aux_req_i[j] latches source 6+j pending, and it stays pending after the input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n_i | input | 3 | Active-low external request lines, asynchronous |
| per_req_i | input | 1 | Peripheral request, active-high level |
| aux_req_i | input | 2 | Pulse requests for sources 6 and 7 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 force/clear, 1 configuration, 2 mask |
| wr_data_i | input | 16 | Register write data |
| ack_i | input | 1 | Sequencer acknowledge pulse |
| ret_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Request to the sequencer |
| src_o | output | 3 | Selected source index |
| vec_o | output | 8 | Vector slot address |
| pend_o | output | 8 | Pending state per source |

## Verification
The hardest state to reach is a full nesting stack, where four levels are in service in strictly rising urgency and a fifth, more urgent source must still be held back. The stimulus builds it by forcing sources 7, 5, 3 and 2 one by one through the force register, acknowledging each as it preempts, then forcing source 0. A single return must release it. The edge-latch timing through the synchronizer is reached with a one-cycle low pulse on an external line, sampled just before and just after the expected latch edge.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
  localparam int NSRC = 8;
  localparam int IW   = $clog2(NSRC);
  localparam int NEXT = 3;
  localparam int NAUX = 2;

  localparam int SRC_PER  = 1;
  localparam int SRC_SWA  = 3;
  localparam int SRC_SWB  = 4;
  localparam int SRC_AUX0 = 6;

  localparam int FC_FORCE_OFS = 8;
  localparam int CFG_NEST_BIT = 4;

  typedef enum logic [1:0] {
    SEL_FC   = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // which source each external line feeds
  function automatic int ext_src(input int k);
    case (k)
      0:       return 0;
      1:       return 2;
      default: return 5;
    endcase
  endfunction

  // lowest set index, zero when none
  function automatic logic [IW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic int slot_addr(input int idx, input int words);
    return idx * words;
  endfunction
endpackage

// File: rtl/ic_sync.sv
`timescale 1ns/1ps
module ic_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_n,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  for (genvar k = 0; k < W; k++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= ~line_n[k];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl_o[k]  = s2;
    assign fall_o[k] = s2 & ~s3;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[k] |=> !fall_o[k]); // R4
  end
endmodule

// File: rtl/ic_pend.sv
`timescale 1ns/1ps
module ic_pend
  import ic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fc_we,
  input  logic [15:0]     fc_data,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] lvl_hold,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] latch_q;
  logic [NSRC-1:0] clr_w, frc_w;

  assign clr_w = fc_we ? fc_data[NSRC-1:0] : '0;
  assign frc_w = fc_we ? fc_data[FC_FORCE_OFS +: NSRC] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~clr_w & ~ack_clr) | frc_w | hw_set;
  end

  assign pend_o = latch_q | lvl_hold;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      frc_w[i] |=> pend_o[i]); // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w[i] && !frc_w[i] && !hw_set[i]) |=> !latch_q[i]); // R2
  end
endmodule

// File: rtl/ic_stack.sv
`timescale 1ns/1ps
module ic_stack
  import ic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [IW-1:0] push_idx,
  output logic [IW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wp, rp;

  assign wp      = cnt_q[AW-1:0];
  assign rp      = wp - 1'b1;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_o   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && pop) begin
      mem[rp] <= push_idx;
    end else if (push && !full_o) begin
      mem[wp] <= push_idx;
      cnt_q   <= cnt_q + 1'b1;
    end else if (pop && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R10
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full_o && !pop)); // R10
endmodule

// File: rtl/core_irq_ctrl.sv
`timescale 1ns/1ps
module core_irq_ctrl
  import ic_pkg::*;
#(
  parameter int STK_DEPTH  = 4,
  parameter int SLOT_WORDS = 4,
  parameter int VEC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_n_i,
  input  logic             per_req_i,
  input  logic [NAUX-1:0]  aux_req_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [15:0]      wr_data_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             irq_o,
  output logic [IW-1:0]    src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NSRC-1:0]  pend_o
);
  logic [NEXT-1:0] edge_q;
  logic            nest_q;
  logic [NSRC-1:0] mask_q;

  logic [NEXT-1:0] ext_lvl, ext_fall;
  logic [NSRC-1:0] hw_set, lvl_hold, ack_clr, cand;
  logic            fc_we, any_cand, eligible, ack_take, do_pop;
  logic [IW-1:0]   sel, stk_top;
  logic            stk_empty, stk_full;

  assign fc_we = wr_en_i && (wr_sel_i == SEL_FC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      nest_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CFG) begin
        edge_q <= wr_data_i[NEXT-1:0];
        nest_q <= wr_data_i[CFG_NEST_BIT];
      end
      if (wr_sel_i == SEL_MASK) mask_q <= wr_data_i[NSRC-1:0];
    end
  end

  ic_sync #(.W(NEXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_n(ext_n_i),
    .lvl_o(ext_lvl), .fall_o(ext_fall)
  );

  always_comb begin
    hw_set   = '0;
    lvl_hold = '0;
    for (int k = 0; k < NEXT; k++) begin
      hw_set[ext_src(k)]   = edge_q[k] & ext_fall[k];
      lvl_hold[ext_src(k)] = ~edge_q[k] & ext_lvl[k];
    end
    lvl_hold[SRC_PER]       = per_req_i;
    hw_set[SRC_AUX0 +: NAUX] = aux_req_i;
  end

  assign ack_take = ack_i & irq_o;
  assign ack_clr  = ack_take ? (NSRC'(1) << sel) : '0;

  ic_pend u_pend (
    .clk(clk), .rst_n(rst_n), .fc_we(fc_we), .fc_data(wr_data_i),
    .hw_set(hw_set), .lvl_hold(lvl_hold), .ack_clr(ack_clr),
    .pend_o(pend_o)
  );

  assign cand     = pend_o & mask_q;
  assign any_cand = |cand;
  assign sel      = first_set(cand);
  assign eligible = stk_empty | (nest_q & ~stk_full & (sel < stk_top));
  assign do_pop   = ret_i & ~stk_empty;

  ic_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_take), .pop(do_pop),
    .push_idx(sel), .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  assign irq_o = any_cand & eligible;
  assign src_o = sel;
  assign vec_o = VEC_W'(slot_addr(int'(sel), SLOT_WORDS));

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_o[src_o] && mask_q[src_o])); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & mask_q) == '0) |-> !irq_o); // R6
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_q && !stk_empty) |-> !irq_o); // R9
  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stk_empty) |-> (src_o < stk_top)); // R10
  AST_SOFT_FORCE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[SRC_SWA]) |->
      $past(fc_we && wr_data_i[FC_FORCE_OFS + SRC_SWA])); // R3
endmodule

// File: tb/core_irq_ctrl_test.sv
`timescale 1ns/100ps
module core_irq_ctrl_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_n_i = 3'b111;
  logic        per_req_i = 1'b0;
  logic [1:0]  aux_req_i = 2'b00;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic        ack_i = 1'b0;
  logic        ret_i = 1'b0;
  logic        irq_o;
  logic [2:0]  src_o;
  logic [7:0]  vec_o;
  logic [7:0]  pend_o;

  int n_cmp = 0;
  int n_bad = 0;

  core_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n_i), .per_req_i(per_req_i),
    .aux_req_i(aux_req_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ack_i(ack_i), .ret_i(ret_i),
    .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .pend_o(pend_o)
  );

  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int  exs [3] = '{0, 2, 5};
  bit  lat [8];
  bit  d1 [3], d2 [3], d3 [3];
  bit  edg [3];
  bit  nest;
  bit  [7:0] msk;
  int  stk [$];

  function automatic void mview(output bit [7:0] p, output int s, output bit q);
    bit [7:0] c;
    bit ok;
    p = '0;
    for (int i = 0; i < 8; i++) p[i] = lat[i];
    for (int k = 0; k < 3; k++) if (!edg[k] && d2[k]) p[exs[k]] = 1'b1;
    if (per_req_i) p[1] = 1'b1;
    c = p & msk;
    s = 0;
    for (int i = 7; i >= 0; i--) if (c[i]) s = i;
    ok = (stk.size() == 0) ||
         (nest && stk.size() < DEPTH && s < stk[stk.size()-1]);
    q = (c != 0) && ok;
  endfunction

  always @(posedge clk) begin
    bit [7:0] p;
    int s;
    bit q, acc, fc;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) lat[i] = 0;
      for (int k = 0; k < 3; k++) begin d1[k] = 0; d2[k] = 0; d3[k] = 0; edg[k] = 0; end
      nest = 0; msk = 0; stk.delete();
    end else begin
      mview(p, s, q);
      acc = ack_i && q;
      fc  = wr_en_i && wr_sel_i == 2'd0;
      for (int i = 0; i < 8; i++) begin
        if (fc && wr_data_i[i]) lat[i] = 0;
        if (acc && s == i) lat[i] = 0;
        if (fc && wr_data_i[8+i]) lat[i] = 1;
      end
      for (int k = 0; k < 3; k++) if (edg[k] && d2[k] && !d3[k]) lat[exs[k]] = 1;
      for (int j = 0; j < 2; j++) if (aux_req_i[j]) lat[6+j] = 1;
      if (ret_i && stk.size() > 0) void'(stk.pop_back());
      if (acc) stk.push_back(s);
      if (wr_en_i && wr_sel_i == 2'd1) begin
        for (int k = 0; k < 3; k++) edg[k] = wr_data_i[k];
        nest = wr_data_i[4];
      end
      if (wr_en_i && wr_sel_i == 2'd2) msk = wr_data_i[7:0];
      for (int k = 0; k < 3; k++) begin
        d3[k] = d2[k]; d2[k] = d1[k]; d1[k] = !ext_n_i[k];
      end
    end
  end

  always begin
    bit [7:0] p;
    int s;
    bit q;
    @(negedge clk);
    #1;
    if (rst_n) begin
      mview(p, s, q);
      n_cmp++;
      if (irq_o !== q || int'(src_o) != s || int'(vec_o) != s * 4 || pend_o !== p) begin
        n_bad++;
        $display("FAIL R6/R7 model t=%0t irq=%0b/%0b src=%0d/%0d vec=%0d/%0d pend=%h/%h",
                 $time, irq_o, q, src_o, s, vec_o, s * 4, pend_o, p);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #0.5; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = 16'h0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  task automatic do_ret();
    ret_i = 1'b1; tick(); ret_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 pend after reset", int'(pend_o), 0);
    chk("R1 irq after reset", int'(irq_o), 0);
    rst_n = 1'b1;
    tick();
    wr(2'd0, 16'h0800);
    chk("R1 mask blocks", int'(irq_o), 0);
    chk("R3 force bit 11", int'(pend_o[3]), 1);
    wr(2'd2, 16'h00FF);
    chk("R7 vec soft A", int'(vec_o), 12);
    chk("R6 irq up", int'(irq_o), 1);
    wr(2'd0, 16'h0008);
    chk("R2 clear", int'(pend_o), 0);
    wr(2'd0, 16'h0808);
    chk("R2 force wins", int'(pend_o[3]), 1);
    wr(2'd0, 16'hA000);
    chk("R6 lowest index", int'(src_o), 3);
    wr(2'd2, 16'h00F7);
    chk("R6 mask skips", int'(src_o), 5);
    chk("R7 vec 5", int'(vec_o), 20);
    wr(2'd2, 16'h00FF);
    wr(2'd0, 16'h00FF);
    chk("R2 clear all", int'(pend_o), 0);

    // software sources untouched by pins
    ext_n_i = 3'b000; per_req_i = 1'b1; aux_req_i = 2'b11;
    tick(4);
    chk("R3 no hw set", int'(pend_o[4:3]), 0);
    ext_n_i = 3'b111; per_req_i = 1'b0; aux_req_i = 2'b00;
    tick(4);
    wr(2'd0, 16'h00FF);

    // peripheral level
    per_req_i = 1'b1;
    tick();
    chk("R7 peripheral vec", int'(vec_o), 4);
    wr(2'd0, 16'h0002);
    chk("R5 clear ignored", int'(pend_o[1]), 1);
    do_ack();
    chk("R5 ack keeps level", int'(pend_o[1]), 1);
    chk("R9 held in service", int'(irq_o), 0);
    do_ret();
    chk("R9 released by return", int'(irq_o), 1);
    per_req_i = 1'b0;
    tick();
    chk("R5 drops on release", int'(pend_o[1]), 0);

    // edge latch on line 0
    wr(2'd1, 16'h0001);
    ext_n_i[0] = 1'b0; tick(); ext_n_i[0] = 1'b1; tick();
    chk("R4 not yet", int'(pend_o[0]), 0);
    tick();
    chk("R4 latched", int'(pend_o[0]), 1);
    tick(3);
    chk("R4 stays", int'(pend_o[0]), 1);
    do_ack();
    chk("R8 ack clears", int'(pend_o[0]), 0);
    wr(2'd0, 16'h0800);
    chk("R9 no take while busy", int'(irq_o), 0);
    do_ret();
    chk("R9 after return", int'(src_o), 3);
    do_ack(); do_ret();
    chk("R8 soft cleared", int'(pend_o), 0);

    // level on line 1
    ext_n_i[1] = 1'b0; tick();
    chk("R5 sync delay", int'(pend_o[2]), 0);
    tick();
    chk("R5 level shows", int'(pend_o[2]), 1);
    ext_n_i[1] = 1'b1; tick(2);
    chk("R5 level gone", int'(pend_o[2]), 0);

    // nesting
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h2000); do_ack();
    wr(2'd0, 16'h4000);
    chk("R10 lower blocked", int'(irq_o), 0);
    wr(2'd0, 16'h0400);
    chk("R10 preempt", int'(irq_o), 1);
    chk("R10 preempt vec", int'(vec_o), 8);
    do_ack();
    do_ret();
    chk("R10 back to level 5", int'(irq_o), 0);
    do_ret();
    chk("R10 idle takes 6", int'(src_o), 6);
    do_ack(); do_ret();
    per_req_i = 1'b1; tick();
    do_ack();
    chk("R10 equal blocked", int'(irq_o), 0);
    do_ret(); per_req_i = 1'b0; tick();

    wr(2'd0, 16'h8000); do_ack();
    wr(2'd0, 16'h2000); do_ack();
    wr(2'd0, 16'h0800); do_ack();
    wr(2'd0, 16'h0400); do_ack();
    wr(2'd0, 16'h0100);
    chk("R10 stack full", int'(irq_o), 0);
    do_ret();
    chk("R10 room again", int'(irq_o), 1);
    chk("R10 src 0", int'(src_o), 0);
    do_ack();
    repeat (4) do_ret();

    aux_req_i = 2'b01; tick(); aux_req_i = 2'b00; tick();
    chk("R11 pulse latched", int'(pend_o[6]), 1);
    tick(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule